// File: doc/BRIEF.md
# Shrinking-Span Reloading Down Counter

This block is a synchronous down counter whose runs get shorter as it goes. Each run counts down to 1. The first run starts at the counter's maximum value, 7 with the default 3-bit width. Every later run starts one lower than the run before it. After the run that starts at 2 and ends at 1, the pattern begins again at the maximum.

Two registers hold the state:

- a count register, which steps down once per enabled clock;
- a limit register, which holds the start value of the current run.

When the count reaches 1, the limit steps down, or wraps back to the maximum after a run that started at 2. On that same edge the count loads the new limit, so runs follow each other with no idle cycle in between. The block drives a one-cycle pulse at the last step of each run and another at the last step of the whole cycle. Logic around the block can use these pulses to sequence shrinking windows or repeating patterns of decreasing length.

Top module: `shrink_dcnt`

## Requirements
- R1: When enable is high and the count is not 1, the count drops by exactly one on the next clock edge. The count output is an unsigned binary number.
- R2: Runs start at 7, 6, 5, 4, 3 and 2, in that order. With the default width, 7 is the maximum value and 2 is the lowest start value.
- R3: A run that starts at 2 counts 2, then 1. The next run then starts at 7, and the six-run pattern repeats without end.
- R4: When enable is high and the count is 1, the next cycle already shows the start value of the next run. The value 0 never appears, and no cycle is spent holding between runs.
- R5: When the reset input is high at a clock edge, the next cycle shows a count of 7 and the limit is set to 7. Reset is synchronous and active high. It wins over enable, both when enable is high and in the middle of a run.
- R6: When enable is low, the count and the limit both hold their values.
- R7: The run_done output is high in exactly those cycles in which enable is high and the count is 1.
- R8: The cycle_done output is high in exactly those cycles in which run_done is high and the current run started at 2.
- R9: One full cycle lasts 27 enabled clocks, counting from reset up to and including the first cycle_done pulse, and from then on between consecutive cycle_done pulses.
- R10: The count never drops below 1 and never exceeds the start value of the current run. The limit always stays between 2 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| count | output | WIDTH (3) | Current count value |
| run_done | output | 1 | Pulses high in the last step of each run |
| cycle_done | output | 1 | Pulses high in the last step of the run that starts at 2 |

## Verification
The bench runs three full cycles with enable held high and checks every output against an arithmetic model of the run lengths. This covers the hand-off between runs, where a design that reloads one edge late would show 0 or repeat 1. It also covers the wrap from 2 back to 7, where a design without it would start a run at 1 or count down into 0. Enable is dropped at several points, including exactly at the last step of a run, so that a design which reloads or moves its limit while idle breaks the sequence. Reset is raised in the middle of a run while enable is high, to catch a design that lets enable win over reset or that clears only one of its two registers.

// File: rtl/shrink_dcnt_pkg.sv
package shrink_dcnt_pkg;

    typedef struct packed {
        logic run_end;
        logic cycle_end;
    } dcnt_evt_t;

endpackage

// File: rtl/shrink_dcnt_detect.sv
module shrink_dcnt_detect
    import shrink_dcnt_pkg::*;
#(
    parameter int WIDTH      = 3,
    parameter int LAST_START = 2
) (
    input  logic             en,
    input  logic [WIDTH-1:0] count_q,
    input  logic [WIDTH-1:0] limit_q,
    output dcnt_evt_t        evt
);
    localparam logic [WIDTH-1:0] ONE_V  = WIDTH'(1);
    localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST_START);

    always_comb begin
        evt           = '0;
        evt.run_end   = en && (count_q == ONE_V);
        evt.cycle_end = evt.run_end && (limit_q == LAST_V);
    end
endmodule

// File: rtl/shrink_dcnt_limit.sv
module shrink_dcnt_limit #(
    parameter int WIDTH      = 3,
    parameter int TOP        = 7,
    parameter int LAST_START = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [WIDTH-1:0] limit_q,
    output logic [WIDTH-1:0] limit_d
);
    localparam logic [WIDTH-1:0] TOP_V  = WIDTH'(TOP);
    localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST_START);

    typedef struct packed {
        logic [WIDTH-1:0] lim;
    } lim_state_t;

    lim_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (advance) begin
            if (st_q.lim == LAST_V) st_d.lim = TOP_V;
            else                    st_d.lim = st_q.lim - WIDTH'(1);
        end
        if (rst) st_d.lim = TOP_V;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign limit_q = st_q.lim;
    assign limit_d = st_d.lim;

    AST_LIMIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (limit_q >= LAST_V) && (limit_q <= TOP_V)); // R10
    AST_LIMIT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (advance && limit_q == LAST_V) |=> (limit_q == TOP_V)); // R3
    AST_LIMIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(limit_q)); // R6
endmodule

// File: rtl/shrink_dcnt_count.sv
module shrink_dcnt_count #(
    parameter int WIDTH = 3,
    parameter int TOP   = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             reload,
    input  logic [WIDTH-1:0] reload_val,
    output logic [WIDTH-1:0] count_q
);
    localparam logic [WIDTH-1:0] TOP_V = WIDTH'(TOP);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (reload)    st_d.cnt = reload_val;
        else if (step) st_d.cnt = st_q.cnt - WIDTH'(1);
        if (rst)       st_d.cnt = TOP_V;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign count_q = st_q.cnt;

    AST_COUNT_FLOOR: assert property (@(posedge clk) disable iff (rst)
        count_q != '0); // R10
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (step && !reload) |=> (count_q == $past(count_q) - WIDTH'(1))); // R1
    AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(count_q)); // R6
    AST_RESET_LOAD: assert property (@(posedge clk)
        rst |=> (count_q == TOP_V)); // R5
endmodule

// File: rtl/shrink_dcnt.sv
module shrink_dcnt
    import shrink_dcnt_pkg::*;
#(
    parameter int WIDTH      = 3,
    parameter int LAST_START = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [WIDTH-1:0] count,
    output logic             run_done,
    output logic             cycle_done
);
    localparam int TOP = (1 << WIDTH) - 1;

    logic [WIDTH-1:0] count_q;
    logic [WIDTH-1:0] limit_q;
    logic [WIDTH-1:0] limit_d;
    dcnt_evt_t        evt;

    shrink_dcnt_detect #(.WIDTH(WIDTH), .LAST_START(LAST_START)) u_detect (
        .en(en), .count_q(count_q), .limit_q(limit_q), .evt(evt)
    );

    shrink_dcnt_limit #(.WIDTH(WIDTH), .TOP(TOP), .LAST_START(LAST_START)) u_limit (
        .clk(clk), .rst(rst), .advance(evt.run_end),
        .limit_q(limit_q), .limit_d(limit_d)
    );

    shrink_dcnt_count #(.WIDTH(WIDTH), .TOP(TOP)) u_count (
        .clk(clk), .rst(rst), .step(en), .reload(evt.run_end),
        .reload_val(limit_d), .count_q(count_q)
    );

    assign count      = count_q;
    assign run_done   = evt.run_end;
    assign cycle_done = evt.cycle_end;

    AST_COUNT_LE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        count_q <= limit_q); // R10
    AST_RUN_RESTART: assert property (@(posedge clk) disable iff (rst)
        run_done |=> (count_q == limit_q)); // R4
    AST_CYCLE_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        cycle_done |-> run_done); // R8
endmodule

// File: tb/test_shrink_dcnt.sv
`timescale 1ns/100ps
module test_shrink_dcnt;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [2:0] count;
    logic       run_done, cycle_done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    int m_cnt = 7;
    int m_lim = 7;
    int en_since = 0;
    int starts_seen[$];

    always #2.5 clk = ~clk;

    shrink_dcnt i_shrink_dcnt (
        .clk(clk), .rst(rst), .en(en),
        .count(count), .run_done(run_done), .cycle_done(cycle_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, check pulses, then check count after the edge.
    task automatic step(input logic e, input logic r);
        int exp_rd, exp_cd;
        bit was_end;
        @(negedge clk);
        en  = e;
        rst = r;
        #1;
        exp_rd = (!r && e && m_cnt == 1) ? 1 : 0;
        exp_cd = (exp_rd == 1 && m_lim == 2) ? 1 : 0;
        if (!r) begin
            chk(run_done == exp_rd[0], "R7 run_done", run_done, exp_rd);
            chk(cycle_done == exp_cd[0], "R8 cycle_done", cycle_done, exp_cd);
            if (e) en_since++;
            if (exp_cd == 1) begin
                chk(en_since == 27, "R9 cycle length", en_since, 27);
                en_since = 0;
            end
        end
        was_end = (exp_rd == 1);
        @(posedge clk);
        #1;
        if (r) begin
            m_cnt = 7; m_lim = 7; en_since = 0;
            chk(count == 3'd7, "R5 reset value", count, 7);
        end else if (!e) begin
            chk(count == m_cnt[2:0], "R6 hold when disabled", count, m_cnt);
        end else if (was_end) begin
            m_lim = (m_lim == 2) ? 7 : m_lim - 1;
            m_cnt = m_lim;
            starts_seen.push_back(m_lim);
            chk(count == m_cnt[2:0], (m_lim == 7) ? "R3 wrap to 7" : "R4 reload", count, m_cnt);
        end else begin
            m_cnt = m_cnt - 1;
            chk(count == m_cnt[2:0], "R1 decrement", count, m_cnt);
        end
        if (!r) chk(count >= 3'd1 && int'(count) <= m_lim, "R10 count bounds", count, m_lim);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // Reset state.
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        chk(count == 3'd7, "R5 reset state", count, 7);

        // Three full cycles, enable always high.
        starts_seen.delete();
        for (int i = 0; i < 81; i++) step(1'b1, 1'b0);
        chk(starts_seen.size() == 18, "R2 run count", starts_seen.size(), 18);
        for (int k = 0; k < starts_seen.size(); k++) begin
            int exp_start;
            exp_start = 6 - (k % 6);
            if (exp_start == 1) exp_start = 7;
            chk(starts_seen[k] == exp_start, "R2 start order", starts_seen[k], exp_start);
        end

        // Gaps in enable: alternate, then stall right at a run end.
        for (int i = 0; i < 40; i++) step(i[0], 1'b0);
        while (m_cnt != 1) step(1'b1, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        for (int i = 0; i < 60; i++) step((i % 3) != 0, 1'b0);

        // Reset mid-run with enable high; reset wins.
        while (m_cnt != 4) step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        chk(count == 3'd7, "R5 reset priority over enable", count, 7);
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule